// File: doc/BRIEF.md
# DAC Cyclic Replay Buffer

This block sits between a DMA engine that fills it and a DAC that drains it. Samples arrive from the DMA side only while a transfer request is high. Each new request starts storing at address zero. When the request drops, the block keeps the index of the last stored word. From then on the DAC side loops through the stored words without end, so one short pattern loaded once is played back as a continuous waveform.

The word width is the per-channel sample width times the number of channels. Channel `c` occupies bits `[c*SAMPLE_W +: SAMPLE_W]`. Both sides share one clock.

Top module: `dac_replay_buf`

## Requirements
- R1: After reset `rd_data` is zero and `overflow` is low.
- R2: A word is stored only in a cycle where `xfer_req` and `wr_valid` are both high. Words offered while `xfer_req` is low never reach the replay output.
- R3: Within a transfer, accepted words go to consecutive addresses starting at 0. Reads have no effect on the write address.
- R4: A rising edge of `xfer_req` restarts the write address at 0. A word accepted in that same cycle lands at address 0.
- R5: A falling edge of `xfer_req` makes the last stored address the replay end point and restarts replay at address 0. If the transfer stored no words, the previous end point and content stay in use.
- R6: Until a transfer with at least one stored word has ended, `rd_data` stays zero whatever `rd_req` does.
- R7: The read address advances only in cycles where `rd_req` is high. `rd_data` shows the word at the current read address one clock after that `rd_req` cycle, and holds its value while `rd_req` is low.
- R8: After the word at the end point is read, the read address returns to 0, so the stored words repeat in order.
- R9: The write address saturates at DEPTH. A word offered at saturation is dropped and sets `overflow`. `overflow` stays set until the next rising edge of `xfer_req`.
- R10: Each channel's sample moves through its own `SAMPLE_W`-bit lane, with channel `c` at bits `[c*SAMPLE_W +: SAMPLE_W]`, unchanged and not mixed with other lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Transfer window from the DMA side |
| wr_valid | input | 1 | Write word present |
| wr_data | input | SAMPLE_W*CHANNELS | Write word, channel c in lane c |
| rd_req | input | 1 | DAC asks for the next word |
| rd_data | output | SAMPLE_W*CHANNELS | Replayed word |
| overflow | output | 1 | Write offered while the buffer was full |

## Verification
The bench builds the block with DEPTH=16, SAMPLE_W=12 and CHANNELS=3. The shallow memory makes saturation and the overflow flag reachable within a single short transfer, and lets replay wrap many times within a few hundred cycles. Three odd-width lanes, each carrying a distinct value, would expose any lane swap or slicing error. The bench also runs transfers shorter than an earlier one, an empty transfer, and random `rd_req` gaps, so that the end point is rebased, kept, and tested against the hold behaviour.

// File: rtl/dac_replay_buf.sv
module dac_replay_buf #(
  parameter int SAMPLE_W = 16,
  parameter int CHANNELS = 4,
  parameter int DEPTH    = 1024
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xfer_req,
  input  logic                         wr_valid,
  input  logic [SAMPLE_W*CHANNELS-1:0] wr_data,
  input  logic                         rd_req,
  output logic [SAMPLE_W*CHANNELS-1:0] rd_data,
  output logic                         overflow
);
  localparam int DW = SAMPLE_W * CHANNELS;
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = AW'(DEPTH) == '0 ? {1'b1, {AW{1'b0}}} : (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          xfer_d;
  logic          loaded;
  logic [AW:0]   wr_ptr;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] last_addr;

  wire         start   = xfer_req & ~xfer_d;
  wire         finish  = ~xfer_req & xfer_d;
  wire [AW:0]  wr_base = start ? '0 : wr_ptr;
  wire         wr_try  = xfer_req & wr_valid;
  wire         wr_en   = wr_try & (wr_base != FULL);
  wire         commit  = finish & (wr_ptr != '0);
  wire [AW:0]  wr_last = wr_ptr - 1'b1;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_base[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_d    <= 1'b0;
      wr_ptr    <= '0;
      overflow  <= 1'b0;
      loaded    <= 1'b0;
      last_addr <= '0;
      rd_addr   <= '0;
      rd_data   <= '0;
    end else begin
      xfer_d <= xfer_req;
      if (wr_en)      wr_ptr <= wr_base + 1'b1;
      else if (start) wr_ptr <= '0;
      if (start)                overflow <= 1'b0;
      else if (wr_try & !wr_en) overflow <= 1'b1;
      if (commit) begin
        last_addr <= wr_last[AW-1:0];
        loaded    <= 1'b1;
      end
      if (commit)
        rd_addr <= '0;
      else if (rd_req && loaded)
        rd_addr <= (rd_addr >= last_addr) ? '0 : rd_addr + 1'b1;
      if (rd_req)
        rd_data <= loaded ? mem[rd_addr] : '0;
    end
  end
endmodule

module dac_replay_buf_chk #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_req,
  input logic          rd_req,
  input logic          loaded,
  input logic          overflow,
  input logic [AW:0]   wr_ptr,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] last_addr,
  input logic [DW-1:0] rd_data
);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |=> rd_data == '0);
  p_wr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_req |=> $stable(wr_ptr));
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |=> wr_ptr <= 1);
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= (AW+1)'(DEPTH));
  p_ovf_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> wr_ptr == (AW+1)'(DEPTH));
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));
  p_wrap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr <= last_addr);
endmodule

bind dac_replay_buf dac_replay_buf_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .rd_req(rd_req),
  .loaded(loaded), .overflow(overflow), .wr_ptr(wr_ptr),
  .rd_addr(rd_addr), .last_addr(last_addr), .rd_data(rd_data)
);

// File: tb/dac_replay_buf_tb.sv
module dac_replay_buf_tb;
  localparam int SW = 12;
  localparam int CH = 3;
  localparam int DP = 16;
  localparam int DW = SW * CH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_req = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic overflow;

  always #2.5 clk = ~clk;

  dac_replay_buf #(.SAMPLE_W(SW), .CHANNELS(CH), .DEPTH(DP)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .overflow(overflow));

  logic [DW-1:0] m_mem [DP];
  logic [DW-1:0] m_rd;
  int  m_wp, m_ra, m_last;
  bit  m_loaded, m_ovf, m_xd;
  int  checks = 0, fails = 0, seq = 0;
  bit  done = 0;
  string tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd = '0; m_wp = 0; m_ra = 0; m_last = 0;
      m_loaded = 0; m_ovf = 0; m_xd = 0;
    end else begin
      bit st, fin;
      st  = xfer_req && !m_xd;
      fin = !xfer_req && m_xd;
      if (rd_req) m_rd = m_loaded ? m_mem[m_ra] : '0;
      if (fin && m_wp > 0) m_ra = 0;
      else if (rd_req && m_loaded) m_ra = (m_ra >= m_last) ? 0 : m_ra + 1;
      if (fin && m_wp > 0) begin m_last = m_wp - 1; m_loaded = 1; end
      if (st) begin m_wp = 0; m_ovf = 0; end
      if (xfer_req && wr_valid) begin
        if (m_wp < DP) begin m_mem[m_wp] = wr_data; m_wp++; end
        else m_ovf = 1;
      end
      m_xd = xfer_req;
    end
  end

  function automatic logic [DW-1:0] mk_word(int s);
    logic [DW-1:0] w;
    for (int c = 0; c < CH; c++) w[c*SW +: SW] = SW'(c * 1024 + s * 7 + 1);
    return w;
  endfunction

  task automatic compare();
    checks++;
    if (rd_data !== m_rd) begin
      fails++;
      $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, m_rd);
    end
    checks++;
    if (overflow !== m_ovf) begin
      fails++;
      $display("FAIL R9 overflow actual %0b expected %0b", overflow, m_ovf);
    end
  endtask

  task automatic step(bit xr, bit wv, bit rr);
    @(negedge clk);
    compare();
    xfer_req = xr; wr_valid = wv; rd_req = rr;
    wr_data = mk_word(seq); seq++;
  endtask

  task automatic transfer(int n, bit gaps);
    int k = 0;
    while (k < n) begin
      bit v = gaps ? 1'($urandom_range(0, 1)) : 1'b1;
      step(1, v, 1'($urandom_range(0, 1)));
      if (v) k++;
    end
    step(0, 0, 1);
  endtask

  task automatic replay(int n, bit gaps);
    for (int i = 0; i < n; i++) step(0, 0, gaps ? 1'($urandom_range(0, 1)) : 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    tag = "R6";  for (int i = 0; i < 8; i++) step(0, 1, 1);
    tag = "R2";  replay(6, 0);
    tag = "R3";  transfer(5, 0);
    tag = "R8";  replay(20, 0);
    tag = "R7";  replay(30, 1);
    tag = "R4";  transfer(3, 1);
    tag = "R8";  replay(12, 0);
    tag = "R5";  step(1, 0, 1); step(0, 0, 1); replay(12, 0);
    tag = "R9";  transfer(DP + 3, 0);
    tag = "R10"; replay(40, 1);
    tag = "R4";  step(1, 1, 1); step(0, 0, 1); replay(6, 0);
    @(negedge clk); compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule